// File: doc/BRIEF.md
# Control-Transfer Next-PC Unit

This block holds the program counter of a small 64-bit core. For each instruction it works out the address of the next instruction, the return address that a call leaves behind, and whether that return address is written to a register. It rebuilds the scrambled conditional-branch and jump immediates as byte offsets from halfword counts. It adds the register-relative target for indirect jumps. It also produces the upper-immediate constant. The decision whether a conditional branch is taken is made elsewhere and arrives as a flag.

The core presents the current instruction word, the value of its first source register and the branch flag. It reads `next_pc_o` as the fetch address of the following instruction. It raises `advance_i` in each cycle in which the instruction retires, and on that edge the counter loads `next_pc_o`. While `advance_i` is low the counter holds its value and no link write is requested.

Top module: `cf_next_pc_unit`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the first advance, `pc_o` equals the parameter `RESET_PC`.
- R2: An instruction whose opcode field (bits 6:0) is none of 1101111, 1100111, 1100011 gives `next_pc_o = pc_o + 4` and `link_we_o = 0`.
- R3: Opcode 1101111 (direct jump) gives `next_pc_o = pc_o + off`. Here `off` is the signed 21-bit value {bit31, bits19:12, bit20, bits30:21, 0}, sign-extended to 64 bits. It also gives `link_o = pc_o + 4`.
- R4: Opcode 1100011 (conditional branch) with `br_taken_i = 1` gives `next_pc_o = pc_o + off`. Here `off` is the signed 13-bit value {bit31, bit7, bits30:25, bits11:8, 0}, sign-extended. Negative offsets wrap below `pc_o`.
- R5: Opcode 1100011 with `br_taken_i = 0` gives `next_pc_o = pc_o + 4`, and the branch never requests a link write.
- R6: Opcode 1100111 (indirect jump) gives `next_pc_o = (rs1_i + sext(bits31:20))` with bit 0 cleared, and `link_o = pc_o + 4`.
- R7: `link_we_o` is high only when `advance_i` is high, the opcode is 1101111 or 1100111, and the destination field (bits 11:7, driven on `link_rd_o`) is nonzero. A destination of 0 drops the write.
- R8: `lui_o` equals bits 31:12 placed in result bits 31:12, with bits 11:0 zero and bit 31 copied into bits 63:32.
- R9: On a rising clock edge with `advance_i` high, `pc_o` takes the value `next_pc_o` had before the edge. With `advance_i` low, `pc_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| advance_i | input | 1 | Instruction retires this cycle |
| instr_i | input | 32 | Current instruction word |
| rs1_i | input | 64 | First source register value |
| br_taken_i | input | 1 | Branch condition result |
| pc_o | output | 64 | Current program counter |
| next_pc_o | output | 64 | Address of the following instruction |
| link_o | output | 64 | Return address (pc_o + 4) |
| link_we_o | output | 1 | Write link_o to register link_rd_o |
| link_rd_o | output | 5 | Link destination register index |
| lui_o | output | 64 | Upper-immediate result |

## Verification
The bench builds the unit with `XLEN = 64` and `RESET_PC = 64'h0000_0000_8000_0000`. A reset address with bit 31 set and upper bits clear means a sign extension that leaks into the upper half of an address shows up at once in the compared values. It also lets negative branch and jump offsets cross down through low address bits without wrapping past zero. Upper-immediate values are chosen with bit 31 both clear and set, so that the copy of bit 31 into the upper word is seen in both directions.

// File: rtl/cf_pkg.sv
package cf_pkg;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;

  typedef enum logic [2:0] {
    CF_SEQ,
    CF_BR,
    CF_JAL,
    CF_JALR,
    CF_LUI
  } cf_kind_e;

  typedef struct packed {
    cf_kind_e   kind;
    logic [4:0] rd;
  } cf_ctrl_t;
endpackage

// File: rtl/cf_decode.sv
module cf_decode
  import cf_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0]     instr_i,
  output cf_ctrl_t        ctrl_o,
  output logic [XLEN-1:0] imm_b_o,
  output logic [XLEN-1:0] imm_j_o,
  output logic [XLEN-1:0] imm_i_o,
  output logic [XLEN-1:0] imm_u_o
);
  localparam int BW = 13;
  localparam int JW = 21;
  localparam int IW = 12;
  localparam int UW = 32;

  logic [BW-1:0] raw_b;
  logic [JW-1:0] raw_j;
  logic [IW-1:0] raw_i;
  logic [UW-1:0] raw_u;

  // reassemble the scrambled fields; bit 0 is the implied halfword zero
  assign raw_b = {instr_i[31], instr_i[7], instr_i[30:25], instr_i[11:8], 1'b0};
  assign raw_j = {instr_i[31], instr_i[19:12], instr_i[20], instr_i[30:21], 1'b0};
  assign raw_i = instr_i[31:20];
  assign raw_u = {instr_i[31:12], 12'b0};

  assign imm_b_o = {{(XLEN-BW){raw_b[BW-1]}}, raw_b};
  assign imm_j_o = {{(XLEN-JW){raw_j[JW-1]}}, raw_j};
  assign imm_i_o = {{(XLEN-IW){raw_i[IW-1]}}, raw_i};
  assign imm_u_o = {{(XLEN-UW){raw_u[UW-1]}}, raw_u};

  always_comb begin
    ctrl_o.rd = instr_i[11:7];
    unique case (instr_i[6:0])
      OPC_JAL:    ctrl_o.kind = CF_JAL;
      OPC_JALR:   ctrl_o.kind = CF_JALR;
      OPC_BRANCH: ctrl_o.kind = CF_BR;
      OPC_LUI:    ctrl_o.kind = CF_LUI;
      default:    ctrl_o.kind = CF_SEQ;
    endcase
  end
endmodule

// File: rtl/cf_target.sv
module cf_target
  import cf_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int INSTR_B = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_i,
  input  cf_kind_e        kind_i,
  input  logic            taken_i,
  input  logic [XLEN-1:0] imm_b_i,
  input  logic [XLEN-1:0] imm_j_i,
  input  logic [XLEN-1:0] imm_i_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic [XLEN-1:0] link_o
);
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] rel_off;
  logic [XLEN-1:0] rel_pc;
  logic [XLEN-1:0] ind_sum;
  logic [XLEN-1:0] ind_pc;

  assign seq_pc  = pc_i + XLEN'(INSTR_B);
  // one shared pc-relative adder for both layouts
  assign rel_off = (kind_i == CF_JAL) ? imm_j_i : imm_b_i;
  assign rel_pc  = pc_i + rel_off;
  assign ind_sum = rs1_i + imm_i_i;
  assign ind_pc  = {ind_sum[XLEN-1:1], 1'b0};

  always_comb begin
    unique case (kind_i)
      CF_JAL:  next_pc_o = rel_pc;
      CF_BR:   next_pc_o = taken_i ? rel_pc : seq_pc;
      CF_JALR: next_pc_o = ind_pc;
      default: next_pc_o = seq_pc;
    endcase
  end

  assign link_o = seq_pc;
endmodule

// File: rtl/cf_pc_reg.sv
module cf_pc_reg #(
  parameter int              XLEN     = 64,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [XLEN-1:0] d_i,
  output logic [XLEN-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RESET_PC;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/cf_next_pc_unit.sv
module cf_next_pc_unit
  import cf_pkg::*;
#(
  parameter int              XLEN     = 64,
  parameter logic [XLEN-1:0] RESET_PC = 64'h0000_0000_8000_0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            advance_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic            br_taken_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic [XLEN-1:0] link_o,
  output logic            link_we_o,
  output logic [4:0]      link_rd_o,
  output logic [XLEN-1:0] lui_o
);
  cf_ctrl_t        ctrl;
  logic [XLEN-1:0] imm_b, imm_j, imm_i;
  logic            is_link;

  cf_decode #(.XLEN(XLEN)) u_dec (
    .instr_i (instr_i),
    .ctrl_o  (ctrl),
    .imm_b_o (imm_b),
    .imm_j_o (imm_j),
    .imm_i_o (imm_i),
    .imm_u_o (lui_o)
  );

  cf_target #(.XLEN(XLEN), .INSTR_B(4)) u_tgt (
    .pc_i      (pc_o),
    .rs1_i     (rs1_i),
    .kind_i    (ctrl.kind),
    .taken_i   (br_taken_i),
    .imm_b_i   (imm_b),
    .imm_j_i   (imm_j),
    .imm_i_i   (imm_i),
    .next_pc_o (next_pc_o),
    .link_o    (link_o)
  );

  cf_pc_reg #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (advance_i),
    .d_i    (next_pc_o),
    .q_o    (pc_o)
  );

  assign is_link   = (ctrl.kind == CF_JAL) || (ctrl.kind == CF_JALR);
  // x0 is hard-wired zero: drop the write
  assign link_we_o = advance_i && is_link && (ctrl.rd != 5'd0);
  assign link_rd_o = ctrl.rd;
endmodule

// File: rtl/cf_next_pc_unit_chk.sv
module cf_next_pc_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            advance_i,
  input logic [31:0]     instr_i,
  input logic            br_taken_i,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] next_pc_o,
  input logic            link_we_o,
  input logic [4:0]      link_rd_o
);
  logic is_ctl;
  assign is_ctl = (instr_i[6:0] == 7'b1101111) || (instr_i[6:0] == 7'b1100111)
               || (instr_i[6:0] == 7'b1100011);

  a_r9_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    advance_i |=> pc_o == $past(next_pc_o));
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !advance_i |=> $stable(pc_o));
  a_r7_x0_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_rd_o == 5'd0) |-> !link_we_o);
  a_r7_no_stall_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !advance_i |-> !link_we_o);
  a_r6_even_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[6:0] == 7'b1100111) |-> !next_pc_o[0]);
  a_r2_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_ctl |-> (next_pc_o == pc_o + XLEN'(4)) && !link_we_o);
  a_r5_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[6:0] == 7'b1100011 && !br_taken_i) |-> (next_pc_o == pc_o + XLEN'(4)) && !link_we_o);
endmodule

bind cf_next_pc_unit cf_next_pc_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .advance_i  (advance_i),
  .instr_i    (instr_i),
  .br_taken_i (br_taken_i),
  .pc_o       (pc_o),
  .next_pc_o  (next_pc_o),
  .link_we_o  (link_we_o),
  .link_rd_o  (link_rd_o)
);

// File: tb/tb_cf_next_pc_unit.sv
module tb_cf_next_pc_unit;
  localparam int          CLK_PERIOD = 10;
  localparam logic [63:0] RST_PC     = 64'h0000_0000_8000_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        advance_i = 1'b0;
  logic [31:0] instr_i = 32'h0000_0013;
  logic [63:0] rs1_i = '0;
  logic        br_taken_i = 1'b0;
  logic [63:0] pc_o, next_pc_o, link_o, lui_o;
  logic        link_we_o;
  logic [4:0]  link_rd_o;

  cf_next_pc_unit #(.XLEN(64), .RESET_PC(RST_PC)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .advance_i(advance_i), .instr_i(instr_i),
    .rs1_i(rs1_i), .br_taken_i(br_taken_i), .pc_o(pc_o), .next_pc_o(next_pc_o),
    .link_o(link_o), .link_we_o(link_we_o), .link_rd_o(link_rd_o), .lui_o(lui_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct {
    logic [63:0] pc, nxt, lnk, lui;
    logic        we, chk_lnk, chk_lui;
    logic [4:0]  rd;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [63:0] pc_m  = RST_PC;
  bit          done  = 0;

  task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [31:0] enc_jal(logic [4:0] rd, int off);
    logic [20:0] j = off[20:0];
    return {j[20], j[10:1], j[11], j[19:12], rd, 7'b1101111};
  endfunction
  function automatic logic [31:0] enc_br(int off);
    logic [12:0] b = off[12:0];
    return {b[12], b[10:5], 5'd6, 5'd5, 3'b000, b[4:1], b[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_jalr(logic [4:0] rd, int imm);
    logic [11:0] i = imm[11:0];
    return {i, 5'd7, 3'b000, rd, 7'b1100111};
  endfunction
  function automatic logic [31:0] enc_lui(logic [4:0] rd, logic [19:0] k);
    return {k, rd, 7'b0110111};
  endfunction

  // driver: apply at negedge, push the expected outcome
  task automatic step(string tag, logic [31:0] ins, logic [63:0] rs1, logic tk,
                      logic adv, logic [63:0] nxt, logic lnk_kind);
    exp_t e;
    @(negedge clk_i);
    instr_i = ins; rs1_i = rs1; br_taken_i = tk; advance_i = adv;
    e.tag = tag; e.pc = pc_m; e.nxt = nxt; e.lnk = pc_m + 64'd4;
    e.chk_lnk = lnk_kind; e.rd = ins[11:7];
    e.we = adv && lnk_kind && (ins[11:7] != 5'd0);
    e.chk_lui = (ins[6:0] == 7'b0110111);
    e.lui = {{32{ins[31]}}, ins[31:12], 12'b0};
    sb_q.push_back(e);
    if (adv) pc_m = nxt;
  endtask

  // monitor: sample a quarter period after the drive edge
  initial begin
    forever begin
      exp_t e;
      @(negedge clk_i);
      #(CLK_PERIOD/4);
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        cmp(e.tag, "pc_o", pc_o, e.pc);
        cmp(e.tag, "next_pc_o", next_pc_o, e.nxt);
        cmp(e.tag, "link_we_o", 64'(link_we_o), 64'(e.we));
        cmp(e.tag, "link_rd_o", 64'(link_rd_o), 64'(e.rd));
        if (e.chk_lnk) cmp(e.tag, "link_o", link_o, e.lnk);
        if (e.chk_lui) cmp(e.tag, "lui_o", lui_o, e.lui);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk_i);
    #1 cmp("R1", "pc_o in reset", pc_o, RST_PC);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1 cmp("R1", "pc_o after reset", pc_o, RST_PC);

    // R2 sequential: addi and a store-like word
    step("R2", 32'h0010_0093, 64'd0, 1'b1, 1'b1, pc_m + 64'd4, 1'b0);
    step("R2", 32'h00B5_3023, 64'd0, 1'b0, 1'b1, pc_m + 64'd4, 1'b0);
    // R3 jal forward, backward, and to x0 (R7)
    step("R3", enc_jal(5'd1, 2000), 64'd0, 1'b0, 1'b1, pc_m + 64'd2000, 1'b1);
    step("R3", enc_jal(5'd1, -1048576), 64'd0, 1'b0, 1'b0, pc_m - 64'd1048576, 1'b1);
    step("R3", enc_jal(5'd5, -36), 64'd0, 1'b0, 1'b1, pc_m - 64'd36, 1'b1);
    step("R7", enc_jal(5'd0, 8), 64'd0, 1'b0, 1'b1, pc_m + 64'd8, 1'b1);
    // R4 taken branch forward/back, extreme negative
    step("R4", enc_br(12), 64'd0, 1'b1, 1'b1, pc_m + 64'd12, 1'b0);
    step("R4", enc_br(-20), 64'd0, 1'b1, 1'b1, pc_m - 64'd20, 1'b0);
    step("R4", enc_br(-4096), 64'd0, 1'b1, 1'b0, pc_m - 64'd4096, 1'b0);
    step("R4", enc_br(4094), 64'd0, 1'b1, 1'b1, pc_m + 64'd4094, 1'b0);
    // R5 not taken
    step("R5", enc_br(-20), 64'd0, 1'b0, 1'b1, pc_m + 64'd4, 1'b0);
    // R6 jalr: odd sum cleared, negative immediate, x0 dest (R7)
    step("R6", enc_jalr(5'd1, 3), 64'h0000_0000_1000_0000, 1'b0, 1'b1,
         64'h0000_0000_1000_0002, 1'b1);
    step("R6", enc_jalr(5'd1, -2048), 64'h0000_0000_2000_0801, 1'b0, 1'b1,
         64'h0000_0000_2000_0000, 1'b1);
    step("R7", enc_jalr(5'd0, 0), 64'h0000_0000_8000_0100, 1'b0, 1'b1,
         64'h0000_0000_8000_0100, 1'b1);
    // R7 stall: jal with advance low requests no write
    step("R7", enc_jal(5'd1, 64), 64'd0, 1'b0, 1'b0, pc_m + 64'd64, 1'b1);
    // R8 lui bit31 clear and set
    step("R8", enc_lui(5'd19, 20'h003D0), 64'd0, 1'b0, 1'b1, pc_m + 64'd4, 1'b0);
    step("R8", enc_lui(5'd19, 20'hABCDE), 64'd0, 1'b0, 1'b1, pc_m + 64'd4, 1'b0);
    // R9 hold then step
    step("R9", 32'h0000_0013, 64'd0, 1'b0, 1'b0, pc_m + 64'd4, 1'b0);
    step("R9", 32'h0000_0013, 64'd0, 1'b0, 1'b1, pc_m + 64'd4, 1'b0);
    step("R9", 32'h0000_0013, 64'd0, 1'b0, 1'b0, pc_m + 64'd4, 1'b0);
    repeat (3) @(negedge clk_i);
    done = 1;
    finish_run();
  end
endmodule